// File: doc/BRIEF.md
# Dual Reload Timer with Latched Interrupts

Two independent down-counters sit behind a simple 32-bit word-register port. Each counter has a reload register, a live count register and a control register. The control word holds a clock-source code and a run mode. Sources 4 to 7 pick one of four tick-enable inputs that run off the shared system clock. Any lower code parks the counter, because it stands for an external or disabled clock. A write to the control register loads the count from the reload register and arms the counter.

When a counter expires, it sets its own latched interrupt bit. Timer 0 drives bit 0 and timer 1 drives bit 1. In periodic mode the counter reloads and keeps running. In one-shot mode it stops at zero. Software masks the latched bits through a mask register and clears them with a write-one-to-clear acknowledge register. A masked status word and one level interrupt output reflect the result.

The register port has no handshake. A write is a single-cycle strobe with address and data. A read is combinational from the address. The block never applies back-pressure, so every access completes in the cycle it is presented.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset both counts, reload values, control words, mask and latched bits are zero, and `irq` is low.
- R2: Word offsets are decoded only when `bus_addr[1:0]` is zero. The offsets are reload0 0x00, count0 0x04, ctrl0 0x08, reload1 0x10, count1 0x14, ctrl1 0x18, mask 0x48, acknowledge 0x4C and status 0x54. Reloads read back all 32 bits, and control and mask read back their used bits. Acknowledge reads zero. Every other offset reads zero and ignores writes.
- R3: A control write stores `wdata[2:0]` as the source code and `wdata[3]` as the mode, copies the reload value into the count, and arms the counter.
- R4: An armed counter with source code 4, 5, 6 or 7 steps on each cycle in which `tick_src[code-4]` is high. The count drops by one while it is above 1.
- R5: With a source code of 0 to 3 the count does not change, whatever the tick inputs do.
- R6: A selected tick while the armed count is 0 or 1 is an expiry. It sets latched bit 0 for timer 0 and latched bit 1 for timer 1, visible one cycle later.
- R7: With mode bit 0 (periodic), an expiry reloads the count from the reload register, so expiries repeat every reload-value ticks.
- R8: With mode bit 1 (one-shot), an expiry leaves the count at 0 and disarms the counter. Later ticks have no effect until the next control write.
- R9: Writing the acknowledge register clears each latched bit whose position is 1 in `wdata[1:0]`.
- R10: If an acknowledge write and an expiry hit the same bit in the same cycle, the bit stays set.
- R11: The status word at 0x54 equals the latched bits ANDed with mask bits `[1:0]`. `irq` is high exactly when the status word is nonzero.
- R12: Register writes take effect at the clock edge that samples them. Reads return the registered state combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | 4 | Tick enables for source codes 4 to 7 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, OR of the masked latched bits |

## Verification
Writes, tick steps, expiries, acknowledges and mask changes all land at the clock edge that samples them. So counts, latched bits, status and `irq` are due one cycle after the stimulus, and a read of any register is due in the same cycle as its address. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from the same inputs, and one nanosecond after each falling edge the bench compares `irq` and the read data for the current address against it. Every expected value therefore includes exactly the one register stage between stimulus and result.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int N_SRC      = 4;
  localparam int TMR_STRIDE = 4;
  localparam int OFS_RELOAD = 0;
  localparam int OFS_COUNT  = 1;
  localparam int OFS_CTRL   = 2;
  localparam int W_MASK     = 18;
  localparam int W_ACK      = 19;
  localparam int W_STAT     = 21;
  localparam int CTL_W      = 4;

  typedef struct packed {
    logic       one_shot;
    logic [2:0] src_sel;
  } tmr_ctl_t;
endpackage

// File: rtl/drt_channel.sv
module drt_channel
  import drt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] reload_in,
  input  tmr_ctl_t         ctl_in,
  input  logic [N_SRC-1:0] tick_src,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cnt_q,
  output tmr_ctl_t         ctl_q,
  output logic             expire
);
  logic armed;
  logic src_tick;
  logic at_end;

  always_comb begin
    src_tick = ctl_q.src_sel[2] & tick_src[ctl_q.src_sel[1:0]];
    at_end   = (cnt_q <= CNT_W'(1));
    expire   = !ctl_we && armed && src_tick && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      ctl_q    <= '0;
      armed    <= 1'b0;
    end else begin
      if (reload_we) reload_q <= reload_in;
      if (ctl_we) begin
        ctl_q <= ctl_in;
        cnt_q <= reload_q;
        armed <= 1'b1;
      end else if (armed && src_tick) begin
        if (at_end) begin
          if (ctl_q.one_shot) begin
            cnt_q <= '0;
            armed <= 1'b0;
          end else begin
            cnt_q <= reload_q;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/drt_irq.sv
module drt_irq #(
  parameter int N_TMR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [N_TMR-1:0] wbits,
  input  logic [N_TMR-1:0] expire,
  output logic [N_TMR-1:0] mask_q,
  output logic [N_TMR-1:0] pend_q,
  output logic [N_TMR-1:0] status,
  output logic             irq
);
  logic [N_TMR-1:0] clr;

  always_comb begin
    clr    = ack_we ? wbits : '0;
    status = pend_q & mask_q;
    irq    = |status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_we) mask_q <= wbits;
      pend_q <= (pend_q & ~clr) | expire;
    end
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  tick_src,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]            word;
  logic                         aligned;
  logic [N_TMR-1:0]             expire;
  logic [N_TMR-1:0][CNT_W-1:0]  reload_q;
  logic [N_TMR-1:0][CNT_W-1:0]  cnt_q;
  tmr_ctl_t [N_TMR-1:0]         ctl_q;
  logic [N_TMR-1:0]             mask_q;
  logic [N_TMR-1:0]             pend_q;
  logic [N_TMR-1:0]             status;
  logic                         mask_we;
  logic                         ack_we;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign mask_we = bus_wr && aligned && (word == WORD_W'(W_MASK));
  assign ack_we  = bus_wr && aligned && (word == WORD_W'(W_ACK));

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    logic reload_we;
    logic ctl_we;
    assign reload_we = bus_wr && aligned && (word == WORD_W'(g*TMR_STRIDE + OFS_RELOAD));
    assign ctl_we    = bus_wr && aligned && (word == WORD_W'(g*TMR_STRIDE + OFS_CTRL));

    drt_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload_we (reload_we),
      .ctl_we    (ctl_we),
      .reload_in (bus_wdata[CNT_W-1:0]),
      .ctl_in    (tmr_ctl_t'(bus_wdata[CTL_W-1:0])),
      .tick_src  (tick_src),
      .reload_q  (reload_q[g]),
      .cnt_q     (cnt_q[g]),
      .ctl_q     (ctl_q[g]),
      .expire    (expire[g])
    );
  end

  drt_irq #(.N_TMR(N_TMR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .wbits   (bus_wdata[N_TMR-1:0]),
    .expire  (expire),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (word == WORD_W'(i*TMR_STRIDE + OFS_RELOAD)) bus_rdata = DATA_W'(reload_q[i]);
        if (word == WORD_W'(i*TMR_STRIDE + OFS_COUNT))  bus_rdata = DATA_W'(cnt_q[i]);
        if (word == WORD_W'(i*TMR_STRIDE + OFS_CTRL))   bus_rdata = DATA_W'(ctl_q[i]);
      end
      if (word == WORD_W'(W_MASK)) bus_rdata = DATA_W'(mask_q);
      if (word == WORD_W'(W_STAT)) bus_rdata = DATA_W'(status);
    end
  end
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic                        irq,
  input logic [N_TMR-1:0]            expire,
  input logic [N_TMR-1:0]            pend_q,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt_q,
  input logic [N_TMR-1:0][3:0]       ctl_q
);
  logic ack_wr;
  assign ack_wr = bus_wr && (bus_addr == ADDR_W'(8'h4C));

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq); // R11

  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(g*16 + 8));

    AST_EXPIRY_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> pend_q[g]); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && bus_wdata[g] && !expire[g]) |=> !pend_q[g]); // R9

    AST_EXPIRY_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && bus_wdata[g] && expire[g]) |=> pend_q[g]); // R10

    AST_PARKED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[g][2] && !ctl_wr) |=> $stable(cnt_q[g])); // R5

    AST_ONESHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[g][3] && cnt_q[g] == '0 && !ctl_wr) |=> (cnt_q[g] == '0)); // R8
  end
endmodule

bind dual_reload_timer drt_checker #(
  .N_TMR(N_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .expire    (expire),
  .pend_q    (pend_q),
  .cnt_q     (cnt_q),
  .ctl_q     (ctl_q)
);

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_src = 4'h0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur = "R1";
  int tick_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  // behavioural model state
  logic [31:0] m_rel [2];
  logic [31:0] m_cnt [2];
  logic [3:0]  m_ctl [2];
  bit          m_arm [2];
  logic [1:0]  m_pend;
  logic [1:0]  m_mask;

  always #2 clk = ~clk;

  dual_reload_timer u_dual_reload_timer (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_rel[0];
      8'h04: return m_cnt[0];
      8'h08: return 32'(m_ctl[0]);
      8'h10: return m_rel[1];
      8'h14: return m_cnt[1];
      8'h18: return 32'(m_ctl[1]);
      8'h48: return 32'(m_mask);
      8'h54: return 32'(m_pend & m_mask);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_rel[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0; m_arm[i] = 0;
      end
      m_pend = 0; m_mask = 0;
    end else begin
      logic [1:0] exp;
      exp = 0;
      for (int i = 0; i < 2; i++) begin
        if (bus_wr && bus_addr == 8'(i*16 + 8)) begin
          m_ctl[i] = bus_wdata[3:0];
          m_cnt[i] = m_rel[i];
          m_arm[i] = 1;
        end else if (m_arm[i] && m_ctl[i][2] && tick_src[m_ctl[i][1:0]]) begin
          if (m_cnt[i] <= 1) begin
            exp[i] = 1;
            if (m_ctl[i][3]) begin m_cnt[i] = 0; m_arm[i] = 0; end
            else m_cnt[i] = m_rel[i];
          end else m_cnt[i] = m_cnt[i] - 1;
        end
        if (bus_wr && bus_addr == 8'(i*16)) m_rel[i] = bus_wdata;
      end
      if (bus_wr && bus_addr == 8'h48) m_mask = bus_wdata[1:0];
      if (bus_wr && bus_addr == 8'h4C) m_pend = m_pend & ~bus_wdata[1:0];
      m_pend = m_pend | exp;
    end
  end

  // compare one nanosecond after every falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if (irq !== (|(m_pend & m_mask))) begin
        errors++;
        $display("FAIL %s irq got %b exp %b", cur, irq, |(m_pend & m_mask));
      end
      checks++;
      if (bus_rdata !== m_read(bus_addr)) begin
        errors++;
        $display("FAIL %s rdata @%h got %h exp %h", cur, bus_addr, bus_rdata, m_read(bus_addr));
      end
    end
  end

  // tick drive on falling edge
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (tick_mode)
      0: tick_src <= 4'h0;
      1: tick_src <= lfsr[3:0];
      default: tick_src <= 4'hF;
    endcase
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic run(input logic [7:0] a, input int n);
    bus_addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep();
    for (int a = 0; a < 96; a += 4) run(8'(a), 1);
    run(8'h05, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = "R1"; sweep();
    cur = "R2";
    wr(8'h00, 32'h1234_5678); wr(8'h10, 32'hAA);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF); wr(8'h58, 32'h3);
    wr(8'h49, 32'h3); wr(8'h4C, 32'h0);
    sweep();
    cur = "R12"; wr(8'h00, 32'd9); run(8'h00, 1);
    cur = "R3"; wr(8'h08, 32'h4); run(8'h04, 2); run(8'h08, 1);
    cur = "R11"; wr(8'h48, 32'h3);
    cur = "R7"; tick_mode = 1; run(8'h04, 60);
    cur = "R4"; wr(8'h10, 32'd2); wr(8'h18, 32'h6); run(8'h14, 30);
    cur = "R6"; run(8'h54, 20);
    cur = "R5"; tick_mode = 2; wr(8'h10, 32'd7); wr(8'h18, 32'h2); run(8'h14, 20);
    cur = "R8"; wr(8'h10, 32'd3); wr(8'h18, 32'hF); run(8'h14, 15); run(8'h54, 2);
    cur = "R11"; wr(8'h48, 32'h1); run(8'h54, 4); wr(8'h48, 32'h2); run(8'h54, 4);
    wr(8'h48, 32'h0); run(8'h54, 4); wr(8'h48, 32'h3);
    cur = "R9"; wr(8'h08, 32'h0); wr(8'h4C, 32'h3); run(8'h54, 4);
    cur = "R10"; wr(8'h00, 32'd0); wr(8'h08, 32'h5); run(8'h54, 3);
    wr(8'h4C, 32'h1); run(8'h54, 3);
    wr(8'h08, 32'h1); wr(8'h4C, 32'h1); run(8'h54, 3);
    tick_mode = 0; sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog cycles got %0d exp <20000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule